// File: doc/BRIEF.md
# Serial Game Pad Button Shifter

This block is the pad-side half of a serial game controller link. Eight button contacts arrive in parallel. A console drives a strobe level and a port clock. The block returns one active-low serial data line that the console reads one bit at a time. While the strobe is held high, the register keeps copying the live button states. Once the strobe drops, each rising edge of the port clock moves the next button onto the line. When all eight buttons have been shifted out, the line carries a constant fill value.

The strobe and port clock come from outside the block's clock domain, so both pass through synchronizer stages before use. Any port-clock edge counts as a shift, including an unwanted extra one, and the block makes no attempt to detect such edges. An extra edge therefore deletes a button from the stream. The console then sees the fill value where the Right button should be.

Top module: `bsr_pad`

## Requirements
- R1: After a synchronous reset the register holds no presses and `data_n` is high.
- R2: While the strobe is high, the register reloads from `btn_pressed` on every system clock, so `data_n` follows `~btn_pressed[0]` as the buttons change.
- R3: While the strobe is high, rising edges of `port_clk` have no effect on `data_n`.
- R4: While the strobe is low and no rising edge of `port_clk` arrives, the captured contents are held, and changes on `btn_pressed` have no effect.
- R5: With the strobe low, each rising edge of `port_clk` advances the register by exactly one bit, and falling edges advance nothing.
- R6: Bit order on the line is `btn_pressed[0]` first, then indices 1 through 7 (A, B, Select, Start, Up, Down, Left, Right). The first bit is on the line before any clock edge.
- R7: The line is active-low. A pressed button (input 1) drives `data_n` low, and a released one drives it high.
- R8: After eight shifts, every further shift presents a pressed-level fill (`data_n` low).
- R9: One extra rising edge of `port_clk` between intended reads deletes one button. The fill then appears in the eighth read, where Right belongs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_pressed | input | NUM_BTN | Button states, 1 = pressed, index 0 = A |
| strobe | input | 1 | Load level from the console, asynchronous |
| port_clk | input | 1 | Shift clock from the console, asynchronous |
| data_n | output | 1 | Active-low serial button data, registered |

## Verification
The bench attacks the strobe-high window in three ways: it changes buttons mid-strobe, pulses the port clock during the strobe, and raises the clock before the strobe falls. A design that loads only on an edge, or that shifts while loading, would show a stale or advanced bit in that window. It then reads past the eighth bit to confirm the fill polarity. A design that shifted in zeros would report released buttons there instead of the pressed-level fill. Finally, it injects an extra port-clock pulse mid-report and expects the Right position to read as pressed. A design that filtered edges, or that shifted on both edges, would give a different stream.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int DEF_NUM_BTN     = 8;
  localparam int DEF_SYNC_STAGES = 2;

  // Button positions in shift order (index into btn_pressed).
  typedef enum int {
    BTN_A = 0, BTN_B = 1, BTN_SELECT = 2, BTN_START = 3,
    BTN_UP = 4, BTN_DOWN = 5, BTN_LEFT = 6, BTN_RIGHT = 7
  } btn_idx_e;

  // Value shifted in behind the last button: reads as "pressed".
  localparam logic FILL_BIT = 1'b1;
endpackage

// File: rtl/bsr_sync.sv
module bsr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

  initial begin
    assert (STAGES >= 1) else $error("bsr_sync needs at least one stage");
  end
endmodule

// File: rtl/bsr_edge.sv
module bsr_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  // R5: a single port-clock edge yields one step pulse, never two in a row
  p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/bsr_shift.sv
module bsr_shift
  import bsr_pkg::*;
#(
  parameter int NB = DEF_NUM_BTN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [NB-1:0] par,
  output logic          ser_n
);
  logic [NB-1:0] sr_q, sr_nxt;

  always_comb begin
    sr_nxt = sr_q;
    if (load)      sr_nxt = par;
    else if (step) sr_nxt = {FILL_BIT, sr_q[NB-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      ser_n <= 1'b1;
    end else begin
      sr_q  <= sr_nxt;
      ser_n <= ~sr_nxt[0];
    end
  end

  // R2: level load tracks the first button on the line
  p_level_load_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (ser_n == ~$past(par[0])));

  // R3: shift requests during load leave the line on the first button
  p_step_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (load && step) |=> (sr_q == $past(par)));

  // R4: no load and no step keeps contents and line
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> ($stable(sr_q) && $stable(ser_n)));

  // R5: a step moves every bit down by one place
  p_shift_one_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> (sr_q[NB-2:0] == $past(sr_q[NB-1:1])));

  // R8: the vacated top position takes the fill value
  p_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> (sr_q[NB-1] == FILL_BIT));
endmodule

// File: rtl/bsr_pad.sv
module bsr_pad
  import bsr_pkg::*;
#(
  parameter int NUM_BTN     = DEF_NUM_BTN,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BTN-1:0] btn_pressed,
  input  logic               strobe,
  input  logic               port_clk,
  output logic               data_n
);
  localparam int CTRL_W = 2;

  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic              strobe_s, pclk_s, pclk_rise;

  assign ctrl_raw = {strobe, port_clk};

  bsr_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctrl_raw),
    .q   (ctrl_s)
  );

  assign strobe_s = ctrl_s[1];
  assign pclk_s   = ctrl_s[0];

  bsr_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pclk_s),
    .rise (pclk_rise)
  );

  bsr_shift #(.NB(NUM_BTN)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (strobe_s),
    .step  (pclk_rise),
    .par   (btn_pressed),
    .ser_n (data_n)
  );

  // R1: the cycle after reset the line is idle high
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> data_n);
endmodule

// File: tb/tb_bsr_pad.sv
module tb_bsr_pad;
  localparam int NB = 8;
  localparam int S  = 2;

  logic clk = 1'b0;
  logic rst, strobe, pclk;
  logic [NB-1:0] btn;
  logic data_n;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit started = 1'b0, done = 1'b0;

  bsr_pad #(.NUM_BTN(NB), .SYNC_STAGES(S)) dut (
    .clk(clk), .rst(rst), .btn_pressed(btn), .strobe(strobe),
    .port_clk(pclk), .data_n(data_n)
  );

  always #2 clk = ~clk;

  // Behavioural model: a queue of read values plus input delay lines.
  bit q[$];
  int str_d[S];
  int pck_d[S];
  int pck_prev;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      q = {};
      for (int i = 0; i < NB; i++) q.push_back(1'b0);
      for (int i = 0; i < S; i++) begin str_d[i] = 0; pck_d[i] = 0; end
      pck_prev = 0;
    end else begin
      if (str_d[S-1] != 0) begin
        q = {};
        for (int i = 0; i < NB; i++) q.push_back(btn[i]);
      end else if (pck_d[S-1] != 0 && pck_prev == 0) begin
        void'(q.pop_front());
        q.push_back(1'b1);
      end
      pck_prev = pck_d[S-1];
      for (int i = S-1; i > 0; i--) begin
        str_d[i] = str_d[i-1];
        pck_d[i] = pck_d[i-1];
      end
      str_d[0] = int'(strobe);
      pck_d[0] = int'(pclk);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) chk(data_n == ~q[0], cur_req, int'(data_n), int'(~q[0]));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    pclk = 1'b1; cyc(hi);
    pclk = 1'b0; cyc(lo);
  endtask

  task automatic load(input logic [NB-1:0] b);
    btn = b; strobe = 1'b1; cyc(4);
    strobe = 1'b0; cyc(4);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  logic [NB-1:0] rd;

  initial begin
    rst = 1'b1; strobe = 1'b0; pclk = 1'b0; btn = '0;
    cyc(3);
    chk(data_n == 1'b1, "R1", int'(data_n), 1);
    rst = 1'b0; cyc(2);
    chk(data_n == 1'b1, "R1", int'(data_n), 1);

    // R2 / R7: level load follows the buttons, pressed drives low
    cur_req = "R2";
    btn = 8'h01; strobe = 1'b1; cyc(4);
    chk(data_n == 1'b0, "R7", int'(data_n), 0);
    btn = 8'h00; cyc(4);
    chk(data_n == 1'b1, "R2", int'(data_n), 1);
    btn = 8'h01; cyc(4);
    chk(data_n == 1'b0, "R2", int'(data_n), 0);

    // R3: clock edges during strobe are ignored
    cur_req = "R3";
    pulse(3, 3); pulse(3, 3); pulse(3, 3);
    chk(data_n == 1'b0, "R3", int'(data_n), 0);

    // R4: hold after strobe falls, button changes ignored
    cur_req = "R4";
    load(8'b1010_0110);
    btn = 8'hFF; cyc(6);
    chk(data_n == 1'b1, "R4", int'(data_n), 1);

    // R5 / R6: read out in order, first bit present before any edge
    cur_req = "R6";
    for (int i = 0; i < NB; i++) begin
      rd[i] = ~data_n;
      pulse(3, 3);
    end
    chk(rd == 8'b1010_0110, "R6", int'(rd), 8'hA6);

    // R8: fill value after eight shifts
    cur_req = "R8";
    for (int i = 0; i < 3; i++) begin
      chk(data_n == 1'b0, "R8", int'(data_n), 0);
      pulse(3, 3);
    end

    // R5: falling edge alone does not shift
    cur_req = "R5";
    btn = 8'b0000_0010; strobe = 1'b1; pclk = 1'b1; cyc(4);
    strobe = 1'b0; cyc(4);
    pclk = 1'b0; cyc(5);
    chk(data_n == 1'b1, "R5", int'(data_n), 1);
    pulse(3, 3);
    chk(data_n == 1'b0, "R5", int'(data_n), 0);

    // R9: extra edge with nothing pressed gives a false Right
    cur_req = "R9";
    load(8'h00);
    for (int i = 0; i < NB; i++) begin
      rd[i] = ~data_n;
      pulse(3, 3);
      if (i == 2) pulse(2, 2);
    end
    chk(rd == 8'h80, "R9", int'(rd), 8'h80);

    // R9: with only Right pressed, it moves one place earlier
    load(8'h80);
    for (int i = 0; i < NB; i++) begin
      rd[i] = ~data_n;
      pulse(3, 3);
      if (i == 0) pulse(2, 2);
    end
    chk(rd == 8'hC0, "R9", int'(rd), 8'hC0);

    // R1: reset mid-stream returns to idle
    cur_req = "R1";
    rst = 1'b1; cyc(2);
    chk(data_n == 1'b1, "R1", int'(data_n), 1);
    rst = 1'b0; cyc(2);
    finish_up();
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end
endmodule